// File: doc/BRIEF.md
# Per-Channel Zero Code Suppressor

This block sits on the transmit side of a framed, unipolar DS-1 path and keeps the ones density on the line at or above the minimum. It takes one DS0 channel octet per beat, together with the channel index, the frame index within the superframe, the superframe format and a flag saying whether robbed-bit signaling is being carried. Each of the 24 channels has its own 2-bit suppression mode. Depending on that mode, the octet is either left alone or rewritten so that it can never reach the line as all zeros.

Beats enter and leave on valid/ready streams, with one register stage in between. An accepted beat appears on the output in the next cycle. When the downstream side holds `out_ready` low, the output beat stays frozen, and `in_ready` drops until that beat is taken. `in_ready` is high whenever the stage is empty or the downstream side is accepting in the same cycle. Configuration is a plain bus, read at the moment a beat is accepted. The framing bit is not part of this stream and never passes through the block. Bipolar substitution, framing generation and signaling insertion are handled elsewhere.

Top module: `zcs_top`

## Requirements
- R1: Channel c's mode is `cfg_mode[2c+1:2c]`, with 00 = off, 01 = bit-7 stuffing, 10 = GTE, 11 = jammed bit 8. In mode 00 the octet passes unchanged.
- R2: Bits are counted from the MSB as bit 1, so bit 7 is `octet[1]` and bit 8 is `octet[0]`. In bit-7 mode an all-zero octet leaves as 8'h02, and any other octet is unchanged.
- R3: In GTE mode, outside robbed-bit frames, an all-zero octet leaves as 8'h01, and any other octet is unchanged.
- R4: In GTE mode, inside a robbed-bit frame, an all-zero octet leaves as 8'h02. A robbed-bit frame is one where `in_rbs_on` is 1 and the 0-based `in_frame` is 5 or 11 with `in_esf`=0, or 5, 11, 17 or 23 with `in_esf`=1.
- R5: In jammed-bit-8 mode every octet leaves as `in_octet | 8'h01`.
- R6: A channel index of 24 or more selects no mode, and the octet passes unchanged.
- R7: A beat accepted when `in_valid && in_ready` is high at a clock edge is presented on `out_valid`/`out_octet` right after that edge. Beats leave in the order they were accepted.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_octet` hold their values. `in_ready` equals `!out_valid || out_ready`.
- R9: During and directly after reset, `out_valid` is 0 and `in_ready` is 1.
- R10: For a channel below 24 whose mode is not 00, the output octet is never 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 48 | Per-channel mode, 2 bits per channel |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_octet | input | 8 | Channel octet, MSB is bit 1 |
| in_chan | input | 5 | Channel index 0..23 |
| in_frame | input | 5 | Frame index within the superframe, 0-based |
| in_esf | input | 1 | 1 = 24-frame format, 0 = 12-frame format |
| in_rbs_on | input | 1 | Robbed-bit signaling is carried |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_octet | output | 8 | Suppressed octet |

## Verification
Back-pressure and new input can fall in the same cycle. A stalled output beat must stay frozen while a rewritten all-zero octet is waiting upstream. Also, when `out_ready` returns, the next beat must be accepted in the same edge that the held beat leaves. The bench provokes this by toggling `out_ready` at random against a steady supply of beats, most of them all-zero, across mixed channel modes and robbed and plain frames. A queue-based model predicts every octet and checks the output on every clock, so any lost, repeated or altered beat is caught.

// File: rtl/zcs_pkg.sv
package zcs_pkg;
  typedef enum logic [1:0] {
    ZCS_OFF  = 2'b00,
    ZCS_B7   = 2'b01,
    ZCS_GTE  = 2'b10,
    ZCS_JAM8 = 2'b11
  } zcs_mode_e;

  localparam int OCTET_W = 8;

  // 1-based bit numbering from the MSB, mapped to vector positions
  localparam int POS_BIT7 = 1;
  localparam int POS_BIT8 = 0;

  typedef struct packed {
    logic [OCTET_W-1:0] octet;
  } zcs_beat_t;
endpackage

// File: rtl/zcs_mode_sel.sv
module zcs_mode_sel
  import zcs_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CW  = 5
) (
  input  logic [2*NCH-1:0] cfg_mode,
  input  logic [CW-1:0]    chan,
  output zcs_mode_e        mode
);
  logic [NCH-1:0] hit;
  logic [1:0]     masked [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c]    = (chan == CW'(c));
    assign masked[c] = hit[c] ? cfg_mode[2*c +: 2] : 2'b00;
  end

  always_comb begin
    logic [1:0] acc;
    acc = 2'b00;
    for (int c = 0; c < NCH; c++) acc = acc | masked[c];
    mode = zcs_mode_e'(acc);
  end
endmodule

// File: rtl/zcs_rbs_frame.sv
module zcs_rbs_frame #(
  parameter int FW = 5
) (
  input  logic [FW-1:0] frame,
  input  logic          esf,
  input  logic          rbs_on,
  output logic          robbed
);
  localparam int SIG_SPACING = 6;
  localparam int SF_LEN      = 12;
  localparam int ESF_LEN     = 24;

  logic in_range;
  logic on_slot;

  always_comb begin
    in_range = esf ? (int'(frame) < ESF_LEN) : (int'(frame) < SF_LEN);
    on_slot  = (int'(frame) % SIG_SPACING) == (SIG_SPACING - 1);
    robbed   = rbs_on && in_range && on_slot;
  end
endmodule

// File: rtl/zcs_rewrite.sv
module zcs_rewrite
  import zcs_pkg::*;
(
  input  zcs_mode_e          mode,
  input  logic               robbed,
  input  logic [OCTET_W-1:0] din,
  output logic [OCTET_W-1:0] dout
);
  logic all_zero;

  always_comb begin
    all_zero = (din == '0);
    dout     = din;
    unique case (mode)
      ZCS_OFF:  dout = din;
      ZCS_B7:   if (all_zero) dout[POS_BIT7] = 1'b1;
      ZCS_GTE:  if (all_zero) begin
                  if (robbed) dout[POS_BIT7] = 1'b1;
                  else        dout[POS_BIT8] = 1'b1;
                end
      ZCS_JAM8: dout[POS_BIT8] = 1'b1;
      default:  dout = din;
    endcase
  end
endmodule

// File: rtl/zcs_stage.sv
module zcs_stage
  import zcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      s_valid,
  output logic      s_ready,
  input  zcs_beat_t s_beat,
  output logic      m_valid,
  input  logic      m_ready,
  output zcs_beat_t m_beat
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_beat  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_beat <= s_beat;
    end
  end
endmodule

// File: rtl/zcs_top.sv
module zcs_top
  import zcs_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CW  = 5,
  parameter int FW  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NCH-1:0]   cfg_mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OCTET_W-1:0] in_octet,
  input  logic [CW-1:0]      in_chan,
  input  logic [FW-1:0]      in_frame,
  input  logic               in_esf,
  input  logic               in_rbs_on,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OCTET_W-1:0] out_octet
);
  zcs_mode_e          mode;
  logic               robbed;
  logic [OCTET_W-1:0] fixed;
  zcs_beat_t          s_beat, m_beat;

  zcs_mode_sel #(.NCH(NCH), .CW(CW)) u_sel (
    .cfg_mode(cfg_mode), .chan(in_chan), .mode(mode)
  );

  zcs_rbs_frame #(.FW(FW)) u_rbs (
    .frame(in_frame), .esf(in_esf), .rbs_on(in_rbs_on), .robbed(robbed)
  );

  zcs_rewrite u_rw (
    .mode(mode), .robbed(robbed), .din(in_octet), .dout(fixed)
  );

  assign s_beat.octet = fixed;

  zcs_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_beat(s_beat),
    .m_valid(out_valid), .m_ready(out_ready), .m_beat(m_beat)
  );

  assign out_octet = m_beat.octet;
endmodule

// File: rtl/zcs_top_chk.sv
module zcs_top_chk #(
  parameter int NCH = 24,
  parameter int CW  = 5,
  parameter int FW  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2*NCH-1:0] cfg_mode,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_octet,
  input logic [CW-1:0]    in_chan,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_octet
);
  logic [1:0] cur_mode;
  logic       take;

  always_comb begin
    cur_mode = 2'b00;
    for (int c = 0; c < NCH; c++)
      if (int'(in_chan) == c) cur_mode = cfg_mode[2*c +: 2];
  end

  assign take = in_valid && in_ready;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_octet)); // R8

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8

  AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R7

  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take && cur_mode == 2'b00 |=> out_octet == $past(in_octet)); // R1

  AST_JAM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    take && cur_mode == 2'b11 |=> out_octet[0]); // R5

  AST_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && cur_mode != 2'b00 |=> out_octet != 8'h00); // R10
endmodule

bind zcs_top zcs_top_chk #(.NCH(NCH), .CW(CW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
  .in_valid(in_valid), .in_ready(in_ready), .in_octet(in_octet),
  .in_chan(in_chan), .out_valid(out_valid), .out_ready(out_ready),
  .out_octet(out_octet)
);

// File: tb/sim_zcs_top.sv
`timescale 1ns/1ps
module sim_zcs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] cfg_mode = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_octet = '0;
  logic [4:0]  in_chan = '0;
  logic [4:0]  in_frame = '0;
  logic        in_esf = 1'b0;
  logic        in_rbs_on = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_octet;

  int tests = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];
  bit in_fire_prev = 0;
  bit out_fire_prev = 0;
  bit stall_prev = 0;
  int pend_exp;
  string pend_tag;

  always #2.5 clk = ~clk;

  zcs_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_octet(in_octet),
    .in_chan(in_chan), .in_frame(in_frame), .in_esf(in_esf),
    .in_rbs_on(in_rbs_on), .out_valid(out_valid), .out_ready(out_ready),
    .out_octet(out_octet)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model built from the requirement text
  function automatic int model(input int oct, input int ch, input int fr,
                               input bit esf, input bit rbs, input logic [47:0] cfg,
                               output string tag);
    int md;
    bit robbed;
    int len;
    len = esf ? 24 : 12;
    robbed = rbs && (fr < len) && (fr % 6 == 5);
    if (ch >= 24) begin tag = "R6"; return oct; end
    md = int'(cfg[2*ch +: 2]);
    case (md)
      0: begin tag = "R1"; return oct; end
      1: begin tag = "R2"; return (oct == 0) ? 2 : oct; end
      2: begin
           if (robbed) begin tag = "R4"; return (oct == 0) ? 2 : oct; end
           tag = "R3"; return (oct == 0) ? 1 : oct;
         end
      default: begin tag = "R5"; return oct | 1; end
    endcase
  endfunction

  task automatic drive(input bit v, input int oct, input int ch, input int fr,
                       input bit esf, input bit rbs, input bit rdy);
    string t;
    in_valid  = v;
    in_octet  = 8'(oct);
    in_chan   = 5'(ch);
    in_frame  = 5'(fr);
    in_esf    = esf;
    in_rbs_on = rbs;
    out_ready = rdy;
    pend_exp  = model(oct, ch, fr, esf, rbs, cfg_mode, t);
    pend_tag  = t;
  endtask

  // Runs at each negedge: account for the previous edge, then check outputs
  task automatic observe();
    if (out_fire_prev && exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (in_fire_prev) begin
      exp_q.push_back(pend_exp);
      tag_q.push_back(pend_tag);
    end
    check(out_valid == (exp_q.size() > 0), "R7 valid", int'(out_valid), int'(exp_q.size() > 0));
    check(in_ready == (!out_valid || out_ready), "R8 ready", int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && exp_q.size() > 0) begin
      check(int'(out_octet) == exp_q[0], stall_prev ? {tag_q[0], " R8 hold"} : tag_q[0],
            int'(out_octet), exp_q[0]);
      if (tag_q[0] != "R1" && tag_q[0] != "R6" && tag_q[0] != "R5")
        check(out_octet != 8'h00, "R10", int'(out_octet), 1);
    end
  endtask

  task automatic step(input bit v, input int oct, input int ch, input int fr,
                      input bit esf, input bit rbs, input bit rdy);
    @(negedge clk);
    observe();
    drive(v, oct, ch, fr, esf, rbs, rdy);
    #0.5;
    in_fire_prev  = in_valid && in_ready;
    out_fire_prev = out_valid && out_ready;
    stall_prev    = out_valid && !out_ready;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // channel c mode = c % 4 : 0 off, 1 bit7, 2 GTE, 3 jam8 (R1)
    for (int c = 0; c < 24; c++) cfg_mode[2*c +: 2] = 2'(c % 4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;

    // Directed corners
    step(1, 0, 1, 0, 0, 0, 1);    // R2 zero -> 02
    step(1, 8'h40, 1, 0, 0, 0, 1);// R2 nonzero passes
    step(1, 0, 2, 3, 0, 1, 1);    // R3 plain frame -> 01
    step(1, 0, 2, 5, 0, 1, 1);    // R4 SF frame 5 robbed -> 02
    step(1, 0, 6, 17, 0, 1, 1);   // R3 frame 17 not robbed in SF
    step(1, 0, 6, 17, 1, 1, 1);   // R4 ESF frame 17 robbed
    step(1, 0, 6, 23, 1, 0, 1);   // R3 signaling off
    step(1, 8'h80, 3, 0, 0, 0, 1);// R5 jam
    step(1, 0, 0, 0, 0, 0, 1);    // R1 off zero passes
    step(1, 0, 27, 5, 1, 1, 1);   // R6 out-of-range channel
    step(1, 0, 5, 0, 0, 0, 0);    // stall begins (R8)
    step(1, 0, 7, 0, 0, 0, 0);
    step(1, 0, 7, 0, 0, 0, 1);    // release and accept together
    step(0, 0, 0, 0, 0, 0, 1);

    // Random traffic with back-pressure and mixed modes
    for (int n = 0; n < 4000; n++) begin
      int oct;
      if (n == 2000)
        for (int c = 0; c < 24; c++) cfg_mode[2*c +: 2] = 2'($urandom_range(0, 3));
      oct = ($urandom_range(0, 1) == 1) ? 0 : int'($urandom_range(0, 255));
      step($urandom_range(0, 3) != 0, oct, int'($urandom_range(0, 31)),
           int'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 2) != 0);
    end
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    observe();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule